// File: doc/BRIEF.md
# NAND Erase and Reset Command Responder

This block plays the device side of a NAND flash command bus for the block-erase and reset commands. Each cycle in which the write strobe is high, the byte on the data input is taken as a command when the command-latch input is high, or as an address byte when the address-latch input is high. An erase is armed by one command byte and followed by a fixed number of row-address bytes. A confirm byte then starts it. The block drops its ready output for a programmable number of cycles and reports the target erase block on a one-cycle launch pulse.

A status-read command puts a status byte on the data output. The byte shows ready/busy, the failure flag that the array model reports when an erase ends, and a flag that records whether a reset interrupted an erase. A reset command clears the command state, aborts a running erase and holds the block busy. The busy time is short when the block was idle and longer when it cut an erase short. A reset is refused while the block is still in its reset state, which holds from power-up or the last reset until an erase sequence is begun.

Top module: `nand_erase_responder`

## Requirements
- R1: After the reset input is released, ready is 1, the data output is not driven (dataOe 0, dataOut 0x00), eraseGo is 0, and a status read returns 0x40.
- R2: The command sequence 0x60, then ADDR_CYC address bytes, then 0xD0 raises eraseGo for exactly one cycle, starting in the cycle after the 0xD0 strobe. In that same cycle ready goes low, and it stays low for exactly ERASE_CYC cycles.
- R3: The erase block is the row address assembled little-endian from the address bytes (byte 0 lowest), truncated to ROW_W bits (18 when LARGE=1, 16 otherwise), with its low 5 bits dropped. The low 5 bits of byte 0 and, for LARGE=1, bits 7:2 of byte 2 have no effect on it.
- R4: LARGE=1 requires three address bytes and LARGE=0 requires two. A 0xD0 that arrives before the full count is ignored.
- R5: A 0xD0 that is not preceded by an armed and fully addressed sequence is ignored: no eraseGo and no busy period.
- R6: Command 0x70 drives dataOe high and places the status byte on dataOut. Bit 6 is 1 when ready and 0 when busy. Bit 0 is the eraseFault input sampled when an erase completes. Bit 1 is 1 when the last operation was an erase aborted by reset. Bits 7 and 5:2 are 0.
- R7: While busy, every command other than 0xFF and 0x70 is ignored, and so is every address byte. No second eraseGo occurs and the busy period is not extended.
- R8: A reset (0xFF) accepted while no erase runs holds ready low for RST_IDLE_CYC cycles and clears status bits 1 and 0.
- R9: A reset during an erase aborts it. Ready is then low for RST_ABORT_CYC cycles counted from the reset, and status afterwards reads 0x42.
- R10: A reset that arrives while the block is in its reset state is ignored: ready stays 1. The reset state holds from power-up or an accepted reset until a 0x60 is accepted.
- R11: A reset strobed in the final busy cycle of an erase is treated as an abort, as in R9, and not as a completed erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdLatch | input | 1 | Marks the strobed byte as a command |
| addrLatch | input | 1 | Marks the strobed byte as an address byte |
| writeStrobe | input | 1 | One-cycle bus write strobe |
| dataIn | input | 8 | Command or address byte |
| eraseFault | input | 1 | Failure flag from the array model, sampled when an erase ends |
| readyBusy | output | 1 | 1 ready, 0 busy |
| dataOut | output | 8 | Status byte during status read, otherwise 0x00 |
| dataOe | output | 1 | High while the status byte is presented |
| eraseGo | output | 1 | One-cycle pulse when an erase launches |
| eraseBlock | output | BLK_W | Target block of the last launched erase |

## Verification
The erase timer can expire in the same clock edge that samples a reset command. The bench provokes this by counting cycles from the confirm strobe and placing the 0xFF strobe on the edge where the busy counter reaches zero, after it has confirmed that ready is still low one sample earlier. The outcome is judged at the ports: the busy time must equal the abort duration, not the idle duration, and the status byte must show the aborted flag with the fault bit clear, even though eraseFault is held high at that edge.

// File: rtl/nand_resp_pkg.sv
package nand_resp_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam logic [7:0] CMD_RESET       = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ADDRFULL,
    ST_ERASING,
    ST_RSTBUSY
  } ctlState_t;

  // strobes from control to datapath, valid for the current edge
  typedef struct packed {
    logic       addrClr;
    logic       addrCap;
    logic [1:0] addrIdx;
    logic       eraseLaunch;
    logic       eraseDone;
    logic       abortMark;
    logic       statClr;
  } ctlStrobe_t;

endpackage

// File: rtl/nand_resp_ctrl.sv
module nand_resp_ctrl
  import nand_resp_pkg::*;
#(
  parameter int ADDR_CYC      = 3,
  parameter int ERASE_CYC     = 40,
  parameter int RST_IDLE_CYC  = 4,
  parameter int RST_ABORT_CYC = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdLatch,
  input  logic       addrLatch,
  input  logic       writeStrobe,
  input  logic [7:0] dataIn,
  output ctlStrobe_t strobe,
  output logic       ready,
  output logic       statusMode
);

  localparam int MAX_A = (ERASE_CYC > RST_IDLE_CYC) ? ERASE_CYC : RST_IDLE_CYC;
  localparam int MAX_CYC = (MAX_A > RST_ABORT_CYC) ? MAX_A : RST_ABORT_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] IDLE_LOAD  = CNT_W'(RST_IDLE_CYC - 1);
  localparam logic [CNT_W-1:0] ABORT_LOAD = CNT_W'(RST_ABORT_CYC - 1);
  localparam logic [1:0] LAST_ADDR = 2'(ADDR_CYC - 1);

  ctlState_t        state, stateNxt;
  logic [CNT_W-1:0] busyCnt, busyCntNxt;
  logic [1:0]       addrCnt, addrCntNxt;
  logic             resetSt, resetStNxt;
  logic             statusModeNxt;
  logic             cmdStb, addrStb, busyNow;

  assign cmdStb  = writeStrobe && cmdLatch && !addrLatch;
  assign addrStb = writeStrobe && addrLatch && !cmdLatch;
  assign busyNow = (state == ST_ERASING) || (state == ST_RSTBUSY);

  always_comb begin
    stateNxt      = state;
    busyCntNxt    = busyCnt;
    addrCntNxt    = addrCnt;
    resetStNxt    = resetSt;
    statusModeNxt = statusMode;
    strobe        = '0;

    // busy timer
    if (busyNow) begin
      if (busyCnt == '0) begin
        stateNxt = ST_IDLE;
        if (state == ST_ERASING) strobe.eraseDone = 1'b1;
      end else begin
        busyCntNxt = busyCnt - 1'b1;
      end
    end

    if (cmdStb) begin
      case (dataIn)
        CMD_RESET: begin
          if (!resetSt) begin
            stateNxt         = ST_RSTBUSY;
            busyCntNxt       = (state == ST_ERASING) ? ABORT_LOAD : IDLE_LOAD;
            strobe.eraseDone = 1'b0;
            strobe.abortMark = (state == ST_ERASING);
            strobe.statClr   = (state != ST_ERASING);
            statusModeNxt    = 1'b0;
            resetStNxt       = 1'b1;
            addrCntNxt       = '0;
          end
        end
        CMD_STATUS: statusModeNxt = 1'b1;
        CMD_ERASE_SETUP: begin
          if (!busyNow) begin
            stateNxt       = ST_ARMED;
            addrCntNxt     = '0;
            strobe.addrClr = 1'b1;
            statusModeNxt  = 1'b0;
            resetStNxt     = 1'b0;
          end
        end
        CMD_ERASE_GO: begin
          if (state == ST_ADDRFULL) begin
            stateNxt           = ST_ERASING;
            busyCntNxt         = ERASE_LOAD;
            strobe.eraseLaunch = 1'b1;
            statusModeNxt      = 1'b0;
          end
        end
        default: begin
          if (!busyNow) begin
            statusModeNxt = 1'b0;
            stateNxt      = ST_IDLE;
          end
        end
      endcase
    end else if (addrStb && state == ST_ARMED) begin
      strobe.addrCap = 1'b1;
      strobe.addrIdx = addrCnt;
      addrCntNxt     = addrCnt + 1'b1;
      if (addrCnt == LAST_ADDR) stateNxt = ST_ADDRFULL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      busyCnt    <= '0;
      addrCnt    <= '0;
      resetSt    <= 1'b1;
      statusMode <= 1'b0;
      ready      <= 1'b1;
    end else begin
      state      <= stateNxt;
      busyCnt    <= busyCntNxt;
      addrCnt    <= addrCntNxt;
      resetSt    <= resetStNxt;
      statusMode <= statusModeNxt;
      ready      <= !((stateNxt == ST_ERASING) || (stateNxt == ST_RSTBUSY));
    end
  end

endmodule

// File: rtl/nand_resp_dp.sv
module nand_resp_dp
  import nand_resp_pkg::*;
#(
  parameter int ROW_W = 18,
  parameter int BLK_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [7:0]       dataIn,
  input  logic             eraseFault,
  input  logic             ready,
  input  logic             statusMode,
  output logic [7:0]       dataOut,
  output logic             dataOe,
  output logic             eraseGo,
  output logic [BLK_W-1:0] eraseBlock
);

  localparam int DROP_W = ROW_W - BLK_W;

  logic [ROW_W-1:0] rowReg;
  logic             failBit, abortBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
    end else if (strobe.addrClr) begin
      rowReg <= '0;
    end else if (strobe.addrCap) begin
      for (int b = 0; b < ROW_W; b++) begin
        if (int'(strobe.addrIdx) == b / 8) rowReg[b] <= dataIn[b % 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseGo    <= 1'b0;
      eraseBlock <= '0;
    end else begin
      eraseGo <= strobe.eraseLaunch;
      if (strobe.eraseLaunch) eraseBlock <= rowReg[ROW_W-1:DROP_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failBit  <= 1'b0;
      abortBit <= 1'b0;
    end else if (strobe.abortMark) begin
      failBit  <= 1'b0;
      abortBit <= 1'b1;
    end else if (strobe.statClr) begin
      failBit  <= 1'b0;
      abortBit <= 1'b0;
    end else if (strobe.eraseDone) begin
      failBit  <= eraseFault;
      abortBit <= 1'b0;
    end
  end

  assign dataOe  = statusMode;
  assign dataOut = statusMode ? {1'b0, ready, 4'b0000, abortBit, failBit} : 8'h00;

endmodule

// File: rtl/nand_erase_responder.sv
module nand_erase_responder
  import nand_resp_pkg::*;
#(
  parameter bit LARGE         = 1'b1,
  parameter int ERASE_CYC     = 40,
  parameter int RST_IDLE_CYC  = 4,
  parameter int RST_ABORT_CYC = 12,
  localparam int ADDR_CYC     = LARGE ? 3 : 2,
  localparam int ROW_W        = LARGE ? 18 : 16,
  localparam int BLK_W        = ROW_W - 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdLatch,
  input  logic             addrLatch,
  input  logic             writeStrobe,
  input  logic [7:0]       dataIn,
  input  logic             eraseFault,
  output logic             readyBusy,
  output logic [7:0]       dataOut,
  output logic             dataOe,
  output logic             eraseGo,
  output logic [BLK_W-1:0] eraseBlock
);

  ctlStrobe_t ctlStb;
  logic       statusMode;

  nand_resp_ctrl #(
    .ADDR_CYC(ADDR_CYC), .ERASE_CYC(ERASE_CYC),
    .RST_IDLE_CYC(RST_IDLE_CYC), .RST_ABORT_CYC(RST_ABORT_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdLatch(cmdLatch), .addrLatch(addrLatch),
    .writeStrobe(writeStrobe), .dataIn(dataIn), .strobe(ctlStb),
    .ready(readyBusy), .statusMode(statusMode)
  );

  nand_resp_dp #(.ROW_W(ROW_W), .BLK_W(BLK_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(ctlStb), .dataIn(dataIn),
    .eraseFault(eraseFault), .ready(readyBusy), .statusMode(statusMode),
    .dataOut(dataOut), .dataOe(dataOe), .eraseGo(eraseGo), .eraseBlock(eraseBlock)
  );

endmodule

// File: rtl/nand_erase_responder_chk.sv
module nand_erase_responder_chk #(
  parameter int BLK_W = 13
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdLatch,
  input logic             writeStrobe,
  input logic [7:0]       dataIn,
  input logic             readyBusy,
  input logic [7:0]       dataOut,
  input logic             dataOe,
  input logic             eraseGo,
  input logic [BLK_W-1:0] eraseBlock
);

  a_r2_go_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    eraseGo |-> !readyBusy);

  a_r2_go_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    eraseGo |=> !eraseGo);

  a_r2_block_moves_only_on_go: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(eraseBlock) |-> eraseGo);

  a_r5_go_needs_confirm: assert property (@(posedge clk) disable iff (!rstN)
    eraseGo |-> $past(writeStrobe && cmdLatch && dataIn == 8'hD0));

  a_r7_no_launch_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    eraseGo |-> $past(readyBusy));

  a_r6_status_ready_bit: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (dataOut[7:2] == {1'b0, readyBusy, 4'b0000}));

  a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == 8'h00));

endmodule

bind nand_erase_responder nand_erase_responder_chk #(.BLK_W(BLK_W)) i_chk (
  .clk(clk), .rstN(rstN), .cmdLatch(cmdLatch), .writeStrobe(writeStrobe),
  .dataIn(dataIn), .readyBusy(readyBusy), .dataOut(dataOut), .dataOe(dataOe),
  .eraseGo(eraseGo), .eraseBlock(eraseBlock)
);

// File: tb/test_nand_erase_responder.sv
module test_nand_erase_responder;

  localparam int ERASE_N = 40;
  localparam int IDLE_N  = 4;
  localparam int ABORT_N = 12;
  localparam int BW      = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdLatch = 1'b0, addrLatch = 1'b0, writeStrobe = 1'b0;
  logic [7:0]    dataIn = 8'h00;
  logic          eraseFault = 1'b0;
  logic          readyBusy, dataOe, eraseGo;
  logic [7:0]    dataOut;
  logic [BW-1:0] eraseBlock;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [BW-1:0] expBlk[$];
  string         expTag[$];

  always #10 clk = ~clk;

  nand_erase_responder #(
    .LARGE(1'b1), .ERASE_CYC(ERASE_N), .RST_IDLE_CYC(IDLE_N), .RST_ABORT_CYC(ABORT_N)
  ) i_nand_erase_responder (
    .clk(clk), .rstN(rstN), .cmdLatch(cmdLatch), .addrLatch(addrLatch),
    .writeStrobe(writeStrobe), .dataIn(dataIn), .eraseFault(eraseFault),
    .readyBusy(readyBusy), .dataOut(dataOut), .dataOe(dataOe),
    .eraseGo(eraseGo), .eraseBlock(eraseBlock)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] blockOf(input logic [7:0] b0, input logic [7:0] b1,
                                             input logic [7:0] b2);
    logic [17:0] row;
    row = {b2[1:0], b1, b0};
    return row[17:5];
  endfunction

  // one bus write; called and returns at a falling edge
  task automatic busWrite(input logic c, input logic a, input logic [7:0] d);
    cmdLatch = c; addrLatch = a; dataIn = d; writeStrobe = 1'b1;
    @(negedge clk);
    writeStrobe = 1'b0; cmdLatch = 1'b0; addrLatch = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);
    busWrite(1'b1, 1'b0, d);
  endtask

  task automatic addr(input logic [7:0] d);
    busWrite(1'b0, 1'b1, d);
  endtask

  task automatic startErase(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input string tag);
    cmd(8'h60); addr(b0); addr(b1); addr(b2);
    expBlk.push_back(blockOf(b0, b1, b2));
    expTag.push_back(tag);
    cmd(8'hD0);
  endtask

  task automatic busyLen(output int len);
    len = 0;
    while (readyBusy == 1'b0 && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic readStatus(input logic [7:0] exp, input string tag);
    cmd(8'h70);
    check(dataOe == 1'b1, {tag, " dataOe"}, int'(dataOe), 1);
    check(dataOut == exp, {tag, " status"}, int'(dataOut), int'(exp));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && eraseGo) begin
      if (expBlk.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5/R7 unexpected eraseGo actual=0x%0h expected=none", eraseBlock);
      end else begin
        logic [BW-1:0] e;
        string t;
        e = expBlk.pop_front();
        t = expTag.pop_front();
        check(eraseBlock == e, {t, " erase block"}, int'(eraseBlock), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(readyBusy == 1'b1, "R1 ready", int'(readyBusy), 1);
    check(dataOe == 1'b0 && dataOut == 8'h00, "R1 bus idle", int'(dataOut), 0);
    check(eraseGo == 1'b0, "R1 no go", int'(eraseGo), 0);

    // R10 reset while in reset state is refused
    cmd(8'hFF);
    check(readyBusy == 1'b1, "R10 repeat reset at power-up", int'(readyBusy), 1);
    readStatus(8'h40, "R1");

    // R5 lone confirm
    cmd(8'hD0);
    check(readyBusy == 1'b1, "R5 lone confirm", int'(readyBusy), 1);

    // R4 too few address bytes
    cmd(8'h60); addr(8'h11); addr(8'h22); cmd(8'hD0);
    check(readyBusy == 1'b1, "R4 short address", int'(readyBusy), 1);

    // R2 normal erase
    eraseFault = 1'b0;
    startErase(8'h1F, 8'hA5, 8'hFF, "R2");
    busyLen(n);
    check(n == ERASE_N, "R2 erase busy length", n, ERASE_N);
    readStatus(8'h40, "R6 clean erase");

    // R3 ignored bits give same block; R6 busy status; R7 ignored while busy
    eraseFault = 1'b1;
    startErase(8'h00, 8'hA5, 8'h03, "R3");
    check(blockOf(8'h00, 8'hA5, 8'h03) == blockOf(8'h1F, 8'hA5, 8'hFF),
          "R3 masked bits", 0, 0);
    readStatus(8'h00, "R6 busy");
    cmd(8'h60); addr(8'h40); addr(8'h41); addr(8'h02); cmd(8'hD0);
    busyLen(n);
    check(n == ERASE_N - 6, "R7 busy not extended", n, ERASE_N - 6);
    readStatus(8'h41, "R6 fault bit");

    // R8 reset while idle
    cmd(8'h60);
    cmd(8'hFF);
    busyLen(n);
    check(n == IDLE_N, "R8 idle reset length", n, IDLE_N);
    readStatus(8'h40, "R8 status cleared");

    // R9 abort
    startErase(8'h20, 8'h03, 8'h01, "R9");
    repeat (10) @(negedge clk);
    cmd(8'hFF);
    busyLen(n);
    check(n == ABORT_N, "R9 abort reset length", n, ABORT_N);
    readStatus(8'h42, "R9 abort status");

    // R10 repeat after abort
    cmd(8'hFF);
    check(readyBusy == 1'b1, "R10 repeat reset", int'(readyBusy), 1);

    // R11 reset on final erase cycle
    startErase(8'hE0, 8'h5A, 8'h02, "R11");
    repeat (ERASE_N - 1) @(negedge clk);
    check(readyBusy == 1'b0, "R11 still busy before edge", int'(readyBusy), 0);
    cmd(8'hFF);
    busyLen(n);
    check(n == ABORT_N, "R11 coincident reset length", n, ABORT_N);
    readStatus(8'h42, "R11 status");

    repeat (3) @(negedge clk);
    check(expBlk.size() == 0, "R2 all launches seen", expBlk.size(), 0);
    eraseFault = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule